// File: doc/BRIEF.md
# Circular Buffer Address Wrapper

This block keeps data pointers inside circular buffers without any software boundary test. It holds one buffer description for the X data space and one for the Y data space. Each description has a lower bound, an upper bound, the number of the pointer register that walks the buffer, and an operating mode. When the pointer datapath steps a pointer by a small signed amount, the block looks up the buffer of the addressed space. If that buffer is active and owns the pointer, it folds any address that crosses a bound back into the buffer. Any other address passes through unchanged.

Every configuration write is checked as it is stored. A forward-only buffer needs its lower bound aligned to the smallest power of two that covers the buffer length. A backward-only buffer needs its upper bound to end on such a boundary. A buffer may run in both directions only when its length is a power of two and it is aligned. A configuration that breaks its rule raises a per-space error flag. Choosing one of the two stack pointer registers raises a per-space warning flag. In both cases the buffer stays inactive. The update path is purely combinational, so it sits inside the pointer-write cycle.

Top module: `modu_addr_unit`

## Requirements
- R1: After reset both buffers are inactive, `cfg_err` and `ptr_warn` read 0, and every update returns `upd_addr + upd_step` truncated to 16 bits, with `wrapped` and `upd_err` low.
- R2: A write with `cfg_we` high stores `cfg_lo`, `cfg_hi`, `cfg_ptr` and `cfg_mode` into the buffer that `cfg_space` picks (0 = X, 1 = Y) at the next rising clock edge. The other buffer and its flags keep their values.
- R3: A write whose mode is not off and whose pointer number is 14 or 15 sets `ptr_warn` for that space and leaves the buffer inactive.
- R4: Mode 01 (forward). For a positive step on the owning pointer, if the sum exceeds `hi` the result is `lo + (sum - hi - 1)` and `wrapped` is 1.
- R5: Mode 10 (backward). For a negative step on the owning pointer, if the sum falls below `lo` the result is `hi - (lo - sum - 1)` and `wrapped` is 1.
- R6: On an active buffer, a sum inside the bounds, or a zero step, is returned unchanged with `wrapped` at 0.
- R7: Forward mode needs `lo` to have zeros in every bit below P, where P is the smallest power of two that is at least `hi - lo + 1`. Otherwise `cfg_err` is set for that space.
- R8: Backward mode needs `hi` to have ones in every bit below P. Otherwise `cfg_err` is set.
- R9: Mode 11 (both directions) is accepted only when the length is a power of two and `lo` is aligned to it. An accepted buffer then wraps at both bounds.
- R10: A step on the owning pointer in the direction the mode does not permit sets `upd_err` and returns the unwrapped sum.
- R11: An update whose pointer number differs from the buffer's pointer, or that addresses an inactive buffer (mode 00, `cfg_err` or `ptr_warn`), returns the unwrapped sum with both flags low.
- R12: A write with a mode other than off and with `hi < lo` sets `cfg_err`.
- R13: `upd_step` is a 4-bit two's-complement value. The supported steps are ±1, ±2, ±4 and ±6, and a step may carry the sum across the 16-bit limit before it wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_space | input | 1 | Space written: 0 = X, 1 = Y |
| cfg_lo | input | 16 | Lower buffer bound, byte address |
| cfg_hi | input | 16 | Upper buffer bound, byte address |
| cfg_ptr | input | 4 | Pointer register that owns the buffer |
| cfg_mode | input | 2 | 00 off, 01 forward, 10 backward, 11 both |
| upd_space | input | 1 | Space of the pointer being stepped |
| upd_ptr | input | 4 | Pointer register being stepped |
| upd_addr | input | 16 | Current pointer value |
| upd_step | input | 4 | Signed step |
| new_addr | output | 16 | Stepped and possibly wrapped address |
| wrapped | output | 1 | A bound was crossed and the address was folded |
| upd_err | output | 1 | Step direction is not allowed by the mode |
| cfg_err | output | 2 | Per-space configuration error, bit 0 = X |
| ptr_warn | output | 2 | Per-space reserved-pointer warning |

## Verification
The bench builds the block with its defaults: two spaces, a 4-bit step and reserved pointers starting at 14. These defaults let it reach both stack-pointer selections and step sums that pass 0xFFFF or drop below zero. Buffer lengths of 17 to 64 bytes put the covering power of two at 32 or 64, so single-bit misalignments of either bound are exposed. A random phase keeps rewriting both spaces with mixed modes and pointers, and a behavioural model is checked against every vector.

// File: rtl/modu_pkg.sv
package modu_pkg;

    localparam int ADDR_W = 16;
    localparam int PTR_W  = 4;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_FWD   = 2'b01,
        MODE_BWD   = 2'b10,
        MODE_BIDIR = 2'b11
    } wrap_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [PTR_W-1:0]  ptr;
        wrap_mode_e        mode;
    } buf_cfg_t;

    // all ones up to the highest set bit of span = P-1 for length span+1
    function automatic logic [ADDR_W-1:0] cover_mask(input logic [ADDR_W-1:0] span);
        logic [ADDR_W-1:0] m;
        m = span;
        for (int s = 1; s < ADDR_W; s = s * 2) begin
            m = m | (m >> s);
        end
        return m;
    endfunction

    function automatic logic len_is_pow2(input logic [ADDR_W-1:0] span);
        logic [ADDR_W:0] len;
        len = {1'b0, span} + {{ADDR_W{1'b0}}, 1'b1};
        return (len & {1'b0, span}) == '0;
    endfunction

endpackage

// File: rtl/modu_cfg_bank.sv
module modu_cfg_bank
    import modu_pkg::*;
#(
    parameter int RSV_PTR_FIRST = 14
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  buf_cfg_t wr_cfg,
    output buf_cfg_t cfg,
    output logic     active,
    output logic     cfg_err,
    output logic     warn
);

    buf_cfg_t          cfg_q;
    logic              err_q, warn_q;
    logic              err_d, warn_d;
    logic [ADDR_W-1:0] span, mask;
    logic              lo_ok, hi_ok, inverted;

    always_comb begin
        inverted = wr_cfg.hi < wr_cfg.lo;
        span     = wr_cfg.hi - wr_cfg.lo;
        mask     = cover_mask(span);
        lo_ok    = (wr_cfg.lo & mask) == '0;
        hi_ok    = (wr_cfg.hi & mask) == mask;
        unique case (wr_cfg.mode)
            MODE_FWD:   err_d = inverted || !lo_ok;
            MODE_BWD:   err_d = inverted || !hi_ok;
            MODE_BIDIR: err_d = inverted || !lo_ok || !len_is_pow2(span);
            default:    err_d = 1'b0;
        endcase
        warn_d = (wr_cfg.mode != MODE_OFF) &&
                 (int'(wr_cfg.ptr) >= RSV_PTR_FIRST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '{lo: '0, hi: '0, ptr: '0, mode: MODE_OFF};
            err_q  <= 1'b0;
            warn_q <= 1'b0;
        end else if (we) begin
            cfg_q  <= wr_cfg;
            err_q  <= err_d;
            warn_q <= warn_d;
        end
    end

    assign cfg     = cfg_q;
    assign cfg_err = err_q;
    assign warn    = warn_q;
    assign active  = (cfg_q.mode != MODE_OFF) && !err_q && !warn_q;

    // R2: nothing changes without a write
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(cfg_q) && $stable(err_q) && $stable(warn_q)));

    // R3: reserved pointer choice raises the warning
    a_r3_reserved_warn: assert property (@(posedge clk) disable iff (rst)
        (we && wr_cfg.mode != MODE_OFF && int'(wr_cfg.ptr) >= RSV_PTR_FIRST) |=> warn);

    // R12: inverted bounds are flagged
    a_r12_inverted_err: assert property (@(posedge clk) disable iff (rst)
        (we && wr_cfg.mode != MODE_OFF && wr_cfg.hi < wr_cfg.lo) |=> cfg_err);

    // R1: write of mode off clears both flags
    a_r1_off_clean: assert property (@(posedge clk) disable iff (rst)
        (we && wr_cfg.mode == MODE_OFF) |=> (!cfg_err && !warn && !active));

endmodule

// File: rtl/modu_wrap.sv
module modu_wrap
    import modu_pkg::*;
#(
    parameter int STEP_W = 4
) (
    input  buf_cfg_t           cfg,
    input  logic               active,
    input  logic [PTR_W-1:0]   ptr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [STEP_W-1:0]  step,
    output logic [ADDR_W-1:0]  new_addr,
    output logic               wrapped,
    output logic               dir_err
);

    localparam int XW = ADDR_W + 2;
    localparam logic signed [XW-1:0] ONE = 1;

    logic signed [XW-1:0] raw, lo_s, hi_s, res;
    logic                 go_up, go_down, owned, fwd_ok, bwd_ok;

    always_comb begin
        raw     = $signed({2'b00, addr}) +
                  $signed({{(XW-STEP_W){step[STEP_W-1]}}, step});
        lo_s    = $signed({2'b00, cfg.lo});
        hi_s    = $signed({2'b00, cfg.hi});
        go_down = step[STEP_W-1];
        go_up   = !step[STEP_W-1] && (step != '0);
        owned   = active && (ptr == cfg.ptr);
        fwd_ok  = (cfg.mode == MODE_FWD) || (cfg.mode == MODE_BIDIR);
        bwd_ok  = (cfg.mode == MODE_BWD) || (cfg.mode == MODE_BIDIR);
        res     = raw;
        wrapped = 1'b0;
        dir_err = 1'b0;
        if (owned && go_up) begin
            if (!fwd_ok) begin
                dir_err = 1'b1;
            end else if (raw > hi_s) begin
                res     = lo_s + (raw - hi_s - ONE);
                wrapped = 1'b1;
            end
        end else if (owned && go_down) begin
            if (!bwd_ok) begin
                dir_err = 1'b1;
            end else if (raw < lo_s) begin
                res     = hi_s - (lo_s - raw - ONE);
                wrapped = 1'b1;
            end
        end
        new_addr = res[ADDR_W-1:0];
    end

endmodule

// File: rtl/modu_addr_unit.sv
module modu_addr_unit
    import modu_pkg::*;
#(
    parameter int NSPACE        = 2,
    parameter int STEP_W        = 4,
    parameter int RSV_PTR_FIRST = 14,
    localparam int SEL_W        = (NSPACE > 1) ? $clog2(NSPACE) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_space,
    input  logic [ADDR_W-1:0]  cfg_lo,
    input  logic [ADDR_W-1:0]  cfg_hi,
    input  logic [PTR_W-1:0]   cfg_ptr,
    input  logic [1:0]         cfg_mode,
    input  logic [SEL_W-1:0]   upd_space,
    input  logic [PTR_W-1:0]   upd_ptr,
    input  logic [ADDR_W-1:0]  upd_addr,
    input  logic [STEP_W-1:0]  upd_step,
    output logic [ADDR_W-1:0]  new_addr,
    output logic               wrapped,
    output logic               upd_err,
    output logic [NSPACE-1:0]  cfg_err,
    output logic [NSPACE-1:0]  ptr_warn
);

    buf_cfg_t    wr_cfg;
    buf_cfg_t    bank_cfg [NSPACE];
    logic        bank_act [NSPACE];
    buf_cfg_t    sel_cfg;
    logic        sel_act;

    assign wr_cfg = '{lo: cfg_lo, hi: cfg_hi, ptr: cfg_ptr, mode: wrap_mode_e'(cfg_mode)};

    for (genvar g = 0; g < NSPACE; g++) begin : g_bank
        modu_cfg_bank #(.RSV_PTR_FIRST(RSV_PTR_FIRST)) i_bank (
            .clk     (clk),
            .rst     (rst),
            .we      (cfg_we && (int'(cfg_space) == g)),
            .wr_cfg  (wr_cfg),
            .cfg     (bank_cfg[g]),
            .active  (bank_act[g]),
            .cfg_err (cfg_err[g]),
            .warn    (ptr_warn[g])
        );
    end

    always_comb begin
        sel_cfg = '{lo: '0, hi: '0, ptr: '0, mode: MODE_OFF};
        sel_act = 1'b0;
        for (int s = 0; s < NSPACE; s++) begin
            if (int'(upd_space) == s) begin
                sel_cfg = bank_cfg[s];
                sel_act = bank_act[s];
            end
        end
    end

    modu_wrap #(.STEP_W(STEP_W)) i_wrap (
        .cfg      (sel_cfg),
        .active   (sel_act),
        .ptr      (upd_ptr),
        .addr     (upd_addr),
        .step     (upd_step),
        .new_addr (new_addr),
        .wrapped  (wrapped),
        .dir_err  (upd_err)
    );

    // R10: a refused direction returns the plain sum
    a_r10_err_passes_raw: assert property (@(posedge clk) disable iff (rst)
        upd_err |-> (new_addr == ADDR_W'(upd_addr +
                     ADDR_W'({{(ADDR_W-STEP_W){upd_step[STEP_W-1]}}, upd_step}))));

    // R10: error and wrap never together
    a_r10_no_wrap_on_err: assert property (@(posedge clk) disable iff (rst)
        !(upd_err && wrapped));

    // R11: flagged buffers never act on an update
    a_r11_flagged_idle: assert property (@(posedge clk) disable iff (rst)
        (cfg_err[upd_space] || ptr_warn[upd_space]) |-> (!wrapped && !upd_err));

    // R11: foreign pointer is untouched
    a_r11_foreign_ptr: assert property (@(posedge clk) disable iff (rst)
        (upd_ptr != sel_cfg.ptr) |-> (!wrapped && !upd_err));

endmodule

// File: tb/test_modu_addr_unit.sv
`timescale 1ns/1ps
module test_modu_addr_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [0:0]  cfg_space;
    logic [15:0] cfg_lo, cfg_hi;
    logic [3:0]  cfg_ptr;
    logic [1:0]  cfg_mode;
    logic [0:0]  upd_space;
    logic [3:0]  upd_ptr;
    logic [15:0] upd_addr;
    logic [3:0]  upd_step;
    logic [15:0] new_addr;
    logic        wrapped, upd_err;
    logic [1:0]  cfg_err, ptr_warn;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // behavioural model state
    int m_lo[2], m_hi[2], m_ptr[2], m_mode[2];
    bit m_err[2], m_warn[2];

    always #2.5 clk = ~clk;

    modu_addr_unit i_modu_addr_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_space(cfg_space),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_ptr(cfg_ptr), .cfg_mode(cfg_mode),
        .upd_space(upd_space), .upd_ptr(upd_ptr), .upd_addr(upd_addr),
        .upd_step(upd_step), .new_addr(new_addr), .wrapped(wrapped),
        .upd_err(upd_err), .cfg_err(cfg_err), .ptr_warn(ptr_warn)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_write(input int sp, input int lo, input int hi, input int ptr, input int mode);
        int len, p;
        m_lo[sp] = lo; m_hi[sp] = hi; m_ptr[sp] = ptr; m_mode[sp] = mode;
        m_warn[sp] = (mode != 0) && (ptr >= 14);
        m_err[sp]  = 0;
        if (mode != 0) begin
            if (hi < lo) m_err[sp] = 1;
            else begin
                len = hi - lo + 1;
                p = 1;
                while (p < len) p = p * 2;
                if (mode == 1) m_err[sp] = (lo % p) != 0;
                if (mode == 2) m_err[sp] = (hi % p) != p - 1;
                if (mode == 3) m_err[sp] = (lo % p) != 0 || p != len;
            end
        end
    endtask

    task automatic cfg_write(input int sp, input int lo, input int hi, input int ptr, input int mode);
        @(negedge clk);
        cfg_we = 1'b1; cfg_space = 1'(sp); cfg_lo = 16'(lo); cfg_hi = 16'(hi);
        cfg_ptr = 4'(ptr); cfg_mode = 2'(mode);
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(sp, lo, hi, ptr, mode);
    endtask

    task automatic check_flags(input string req);
        check(req, int'(cfg_err), {m_err[1], m_err[0]}, "cfg_err");
        check(req, int'(ptr_warn), {m_warn[1], m_warn[0]}, "ptr_warn");
    endtask

    // one update; tag "" lets the model name the governing requirement
    task automatic step(input int sp, input int ptr, input int addr, input int stp, input string tag);
        int raw, e_addr;
        bit e_wrap, e_err, act, own;
        string req;
        @(negedge clk);
        upd_space = 1'(sp); upd_ptr = 4'(ptr); upd_addr = 16'(addr); upd_step = 4'(stp);
        #1;
        raw = addr + stp;
        e_addr = raw; e_wrap = 0; e_err = 0; req = "R11";
        act = (m_mode[sp] != 0) && !m_err[sp] && !m_warn[sp];
        own = act && (ptr == m_ptr[sp]);
        if (own) begin
            req = "R6";
            if (stp > 0) begin
                if (m_mode[sp] == 2) begin e_err = 1; req = "R10"; end
                else if (raw > m_hi[sp]) begin
                    e_addr = m_lo[sp] + (raw - m_hi[sp] - 1); e_wrap = 1; req = "R4";
                end
            end else if (stp < 0) begin
                if (m_mode[sp] == 1) begin e_err = 1; req = "R10"; end
                else if (raw < m_lo[sp]) begin
                    e_addr = m_hi[sp] - (m_lo[sp] - raw - 1); e_wrap = 1; req = "R5";
                end
            end
        end
        if (tag != "") req = tag;
        check(req, int'(new_addr), e_addr & 16'hFFFF, "new_addr");
        check(req, int'(wrapped), int'(e_wrap), "wrapped");
        check(req, int'(upd_err), int'(e_err), "upd_err");
        check_flags(req);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int steps[8] = '{-6, -4, -2, -1, 1, 2, 4, 6};
        rst = 1'b1; cfg_we = 0; cfg_space = 0; cfg_lo = 0; cfg_hi = 0; cfg_ptr = 0;
        cfg_mode = 0; upd_space = 0; upd_ptr = 0; upd_addr = 0; upd_step = 0;
        for (int s = 0; s < 2; s++) model_write(s, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        step(0, 0, 16'h0000, 1, "R1");
        step(1, 0, 16'hFFFF, 2, "R1");

        // R4 / R6 / R10 forward buffer in X, length 20
        cfg_write(0, 16'h1000, 16'h1013, 8, 1);
        step(0, 8, 16'h1012, 2, "R4");
        step(0, 8, 16'h1010, 6, "R4");
        step(0, 8, 16'h1004, 4, "R6");
        step(0, 8, 16'h1013, 1, "R4");
        step(0, 8, 16'h1004, -2, "R10");
        step(0, 9, 16'h1012, 2, "R11");

        // R5 backward buffer in Y, length 28; R2 X unaffected
        cfg_write(1, 16'h2004, 16'h201F, 10, 2);
        step(1, 10, 16'h2006, -4, "R5");
        step(1, 10, 16'h2004, -1, "R5");
        step(1, 10, 16'h2010, -6, "R6");
        step(1, 10, 16'h2010, 2, "R10");
        step(0, 8, 16'h1012, 2, "R2");

        // R7 misaligned forward
        cfg_write(0, 16'h1002, 16'h1015, 8, 1);
        step(0, 8, 16'h1014, 4, "R7");
        // R8 misaligned backward
        cfg_write(1, 16'h2000, 16'h2010, 10, 2);
        step(1, 10, 16'h2000, -2, "R8");

        // R9 bidirectional, length 64
        cfg_write(0, 16'h3000, 16'h303F, 11, 3);
        step(0, 11, 16'h303E, 4, "R9");
        step(0, 11, 16'h3001, -4, "R9");
        step(0, 11, 16'h3010, 6, "R9");
        cfg_write(0, 16'h3000, 16'h302F, 11, 3);
        step(0, 11, 16'h302E, 4, "R9");

        // R3 reserved pointers
        cfg_write(1, 16'h4000, 16'h401F, 14, 1);
        step(1, 14, 16'h401E, 4, "R3");
        cfg_write(1, 16'h4000, 16'h401F, 15, 2);
        step(1, 15, 16'h4000, -4, "R3");

        // R12 inverted bounds
        cfg_write(0, 16'h5020, 16'h5000, 8, 1);
        step(0, 8, 16'h5030, 2, "R12");

        // R13 sums across the 16-bit limit
        cfg_write(0, 16'hFFC0, 16'hFFFF, 12, 3);
        step(0, 12, 16'hFFFE, 6, "R13");
        step(0, 12, 16'hFFC1, -6, "R13");
        cfg_write(1, 16'h0000, 16'h000F, 9, 2);
        step(1, 9, 16'h0002, -6, "R13");

        // random phase against the model
        for (int v = 0; v < 600; v++) begin
            if (v % 30 == 0) begin
                int sp, base, len, mode, ptr;
                sp   = $urandom_range(0, 1);
                base = $urandom_range(0, 255) * 64 + (($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0);
                len  = $urandom_range(0, 1) ? 32 : $urandom_range(17, 64);
                mode = $urandom_range(0, 3);
                ptr  = $urandom_range(8, 15);
                if (mode == 2 && $urandom_range(0, 1)) base = base + (64 - len);
                cfg_write(sp, base, base + len - 1, ptr, mode);
            end
            begin
                int sp, a;
                sp = $urandom_range(0, 1);
                a  = m_lo[sp] + $urandom_range(0, 80) - 8;
                step(sp, (m_ptr[sp] + ($urandom_range(0, 5) == 0 ? 1 : 0)) % 16,
                     a & 16'hFFFF, steps[$urandom_range(0, 7)], "");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule